// File: doc/BRIEF.md
# ChaCha Block Permutation Core

This block applies the ChaCha permutation to one 512-bit state held as a 4x4 grid of 32-bit words. A pulse on `start` captures the state and a round count. The core then alternates column half rounds and diagonal half rounds, spending one clock on each half. It finishes by adding the captured input back onto the permuted grid word by word, and signals the result with a single-cycle `done` pulse.

Four quarterround datapaths work side by side, one for each column. For the diagonal half round, rows b, c and d are turned by one, two and three lanes before the quarterround datapaths and turned back after them. Word addressing never changes. The round count is consumed two at a time. At least one double round always runs, and the core stops as soon as taking two from the remaining count would give zero or go negative.

Top module: `chacha_perm_core`

## Requirements
- R1: After reset, `done` and `busy` are low and `state_out` is all zeros.
- R2: The permutation matches the standard ChaCha quarterround sequence. In each quarterround, a+=b, d^=a, d<<<16; c+=d, b^=c, b<<<12; a+=b, d^=a, d<<<8; c+=d, b^=c, b<<<7. Additions wrap modulo 2^32. A column round acts on lanes (0,4,8,12),(1,5,9,13),(2,6,10,14),(3,7,11,15). A diagonal round acts on (0,5,10,15),(1,6,11,12),(2,7,8,13),(3,4,9,14). With a count of 20 and the all-zero key, counter and nonce, the output is the published first keystream block.
- R3: A round count c gives max(1, ceil(c/2)) double rounds, so c=0, c=1 and c=2 each give exactly one.
- R4: Output word i equals the permuted word i plus input word i, modulo 2^32.
- R5: `done` rises 2D+1 clock edges after the edge that accepts `start`, where D is the number of double rounds. It stays high for exactly one cycle.
- R6: `busy` is high from the cycle after acceptance until `done` is raised, and is low while `done` is high. A `start` seen while `busy` is high has no effect on the result or the timing.
- R7: `state_out` changes only in the cycle `done` is high, and holds its value otherwise.
- R8: Word i of `state_in` and `state_out` occupies bits [32i+31:32i]. Words 0-3 form row a, 4-7 row b, 8-11 row c and 12-15 row d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to permute `state_in`; taken only when idle |
| rounds | input | 8 | Round count, consumed two per double round |
| state_in | input | 512 | Input state, word i at bits [32i+31:32i] |
| state_out | output | 512 | Permuted state plus input, held until the next completion |
| done | output | 1 | One-cycle pulse when `state_out` is refreshed |
| busy | output | 1 | High while a permutation is in progress |

## Verification
Any corruption of the working grid, such as a wrong rotate, a lane shifted too far or a missed unrotate, spreads through the additions to every output word within one double round. It is therefore visible on `state_out` at the next `done`. A fault in the round counter appears instead as a `done` pulse that comes early or late, and the bench counts edges to expose it even when the data would otherwise be plausible. A broken feedforward or save register shows up as a mismatch that is present even for a single double round.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int ROWS    = 4;
  localparam int STATE_W = WORD_W * LANES * ROWS;

  // quarterround rotate distances, applied in this order
  localparam int ROT_1 = 16;
  localparam int ROT_2 = 12;
  localparam int ROT_3 = 8;
  localparam int ROT_4 = 7;

  typedef logic [WORD_W-1:0]                   word_t;
  typedef logic [ROWS-1:0][LANES-1:0][WORD_W-1:0] grid_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COL  = 2'd1,
    PH_DIAG = 2'd2,
    PH_FIN  = 2'd3
  } phase_e;

  function automatic word_t rotl(input word_t v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/chacha_rst_sync.sv
module chacha_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;
  word_t a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, ROT_1);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, ROT_2);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, ROT_3);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, ROT_4);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/chacha_half.sv
module chacha_half
  import chacha_pkg::*;
#(
  parameter bit DIAG = 1'b0
) (
  input  grid_t st_i,
  output grid_t st_o
);
  grid_t pre, post;

  // row r is turned left by r lanes for the diagonal variant
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_col
      localparam int SRC = DIAG ? ((l + r) % LANES) : l;
      localparam int DST = DIAG ? ((l - r + LANES) % LANES) : l;
      assign pre[r][l]  = st_i[r][SRC];
      assign st_o[r][l] = post[r][DST];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    chacha_qr u_qr (
      .a_i (pre[0][l]),
      .b_i (pre[1][l]),
      .c_i (pre[2][l]),
      .d_i (pre[3][l]),
      .a_o (post[0][l]),
      .b_o (post[1][l]),
      .c_o (post[2][l]),
      .d_o (post[3][l])
    );
  end
endmodule

// File: rtl/chacha_ctrl.sv
module chacha_ctrl
  import chacha_pkg::*;
#(
  parameter int RND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RND_W-1:0] rounds,
  output logic             load,
  output logic             step,
  output logic             sel_diag,
  output logic             fin,
  output logic             busy
);
  localparam logic [RND_W-1:0] DEC = RND_W'(2);

  phase_e           ph_q, ph_d;
  logic [RND_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    ph_d   = ph_q;
    rem_d  = rem_q;
    rem_en = 1'b0;
    load   = 1'b0;
    step   = 1'b0;
    fin    = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          load   = 1'b1;
          rem_d  = rounds;
          rem_en = 1'b1;
          ph_d   = PH_COL;
        end
      end
      PH_COL: begin
        step = 1'b1;
        ph_d = PH_DIAG;
      end
      PH_DIAG: begin
        step   = 1'b1;
        rem_d  = rem_q - DEC;
        rem_en = 1'b1;
        // stop when subtracting two gives zero or borrows
        ph_d   = (rem_q <= DEC) ? PH_FIN : PH_COL;
      end
      PH_FIN: begin
        fin  = 1'b1;
        ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign sel_diag = (ph_q == PH_DIAG);
  assign busy     = (ph_q != PH_IDLE);
endmodule

// File: rtl/chacha_perm_core.sv
module chacha_perm_core
  import chacha_pkg::*;
#(
  parameter int RND_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RND_W-1:0]   rounds,
  input  logic [STATE_W-1:0] state_in,
  output logic [STATE_W-1:0] state_out,
  output logic               done,
  output logic               busy
);
  logic  rst_i_n;
  logic  load, step, sel_diag, fin;
  grid_t st_q, st_d, save_q, out_q, out_d;
  grid_t col_nx, diag_nx, sum;
  logic  st_en, done_q;

  chacha_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  chacha_ctrl #(.RND_W(RND_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .rounds   (rounds),
    .load     (load),
    .step     (step),
    .sel_diag (sel_diag),
    .fin      (fin),
    .busy     (busy)
  );

  chacha_half #(.DIAG(1'b0)) u_col (
    .st_i (st_q),
    .st_o (col_nx)
  );

  chacha_half #(.DIAG(1'b1)) u_diag (
    .st_i (st_q),
    .st_o (diag_nx)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_ffr
    for (genvar l = 0; l < LANES; l++) begin : g_ffl
      assign sum[r][l] = st_q[r][l] + save_q[r][l];
    end
  end

  always_comb begin
    st_en = load | step;
    if (load)          st_d = grid_t'(state_in);
    else if (sel_diag) st_d = diag_nx;
    else               st_d = col_nx;
    out_d = sum;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  save_q <= '0;
    else if (load) save_q <= grid_t'(state_in);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) out_q <= '0;
    else if (fin) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) done_q <= 1'b0;
    else          done_q <= fin;
  end

  assign state_out = STATE_W'(out_q);
  assign done      = done_q;
endmodule

// File: rtl/chacha_perm_core_chk.sv
module chacha_perm_core_chk #(
  parameter int STATE_W = 512
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               done,
  input logic               busy,
  input logic [STATE_W-1:0] state_out
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R6
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R6
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(state_out));
endmodule

bind chacha_perm_core chacha_perm_core_chk #(.STATE_W(chacha_pkg::STATE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .busy      (busy),
  .state_out (state_out)
);

// File: tb/chacha_perm_core_bench.sv
module chacha_perm_core_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [7:0]   rounds;
  logic [511:0] state_in;
  logic [511:0] state_out;
  logic         done, busy;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  chacha_perm_core u_chacha_perm_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rounds    (rounds),
    .state_in  (state_in),
    .state_out (state_out),
    .done      (done),
    .busy      (busy)
  );

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic void qr(inout logic [31:0] a, inout logic [31:0] b,
                             inout logic [31:0] c, inout logic [31:0] d);
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
  endfunction

  function automatic int dbl(input int rc);
    return (rc <= 2) ? 1 : (rc + 1) / 2;
  endfunction

  function automatic logic [511:0] model(input logic [511:0] s, input int rc);
    logic [31:0] x [16];
    logic [511:0] o;
    for (int i = 0; i < 16; i++) x[i] = s[32*i +: 32];
    for (int k = 0; k < dbl(rc); k++) begin
      qr(x[0], x[4], x[8],  x[12]);
      qr(x[1], x[5], x[9],  x[13]);
      qr(x[2], x[6], x[10], x[14]);
      qr(x[3], x[7], x[11], x[15]);
      qr(x[0], x[5], x[10], x[15]);
      qr(x[1], x[6], x[11], x[12]);
      qr(x[2], x[7], x[8],  x[13]);
      qr(x[3], x[4], x[9],  x[14]);
    end
    for (int i = 0; i < 16; i++) o[32*i +: 32] = x[i] + s[32*i +: 32];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // one permutation; poke drives a stray start while busy
  task automatic run_vec(input logic [511:0] s, input int rc, input bit poke,
                         input string tag);
    logic [511:0] exp;
    int n;
    int lat;
    exp = model(s, rc);
    lat = 2 * dbl(rc) + 2;
    @(negedge clk);
    state_in = s; rounds = 8'(rc); start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    chk(busy == 1'b1, {"R6 busy after accept ", tag}, 512'(busy), 512'(1));
    if (poke) begin
      state_in = ~s; rounds = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0; n++;
    end
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(n == lat, {"R3/R5 latency ", tag}, 512'(n - 1), 512'(lat - 1));
    chk(state_out == exp, {"R2/R4 result ", tag}, state_out, exp);
    chk(busy == 1'b0, {"R6 idle at done ", tag}, 512'(busy), 512'(0));
    @(negedge clk);
    chk(done == 1'b0, {"R5 single pulse ", tag}, 512'(done), 512'(0));
    chk(state_out == exp, {"R7 output held ", tag}, state_out, exp);
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [511:0] kv, kexp, rs;
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; start = 1'b0; rounds = '0; state_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(done == 1'b0 && busy == 1'b0, "R1 reset flags", 512'({done, busy}), 512'(0));
    chk(state_out == '0, "R1 reset output", state_out, '0);

    // R2 R8 published block: constants, zero key/counter/nonce
    kv = '0;
    kv[31:0] = 32'h61707865; kv[63:32] = 32'h3320646e;
    kv[95:64] = 32'h79622d32; kv[127:96] = 32'h6b206574;
    kexp = {32'h8665eeb2, 32'h69b687c3, 32'h1ca11815, 32'hf4b8436a,
            32'h374ad8b8, 32'h3fe02477, 32'h8d485751, 32'h7c5941da,
            32'hc70d778b, 32'hccef36a8, 32'h1aed8da0, 32'hb819d2bd,
            32'h28bd8653, 32'he56a5d40, 32'h903df1a0, 32'hade0b876};
    run_vec(kv, 20, 1'b0, "R2 known block");
    chk(state_out == kexp, "R2 R8 known keystream", state_out, kexp);
    chk(model(kv, 20) == kexp, "R2 bench model", model(kv, 20), kexp);

    // R3 small counts all give one double round
    run_vec(kv, 0, 1'b0, "R3 count0");
    run_vec(kv, 1, 1'b0, "R3 count1");
    run_vec(kv, 2, 1'b0, "R3 count2");
    run_vec(kv, 3, 1'b0, "R3 count3");
    // R4 all-ones input exercises wrap in feedforward
    run_vec({512{1'b1}}, 8, 1'b0, "R4 wrap");
    // R6 stray start while busy
    run_vec(kv, 12, 1'b1, "R6 poke");

    for (int i = 0; i < 24; i++) begin
      for (int w = 0; w < 16; w++) rs[32*w +: 32] = $urandom;
      run_vec(rs, int'($urandom_range(0, 23)), (i % 3) == 0, "random");
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
    end
    summary();
  end
endmodule